// File: doc/BRIEF.md
# Header-Locked Frame Aligner

The block takes a receive bit stream that has already been deserialized into narrow words, and recovers the boundaries of the fixed-length 120-bit frames carried in it. Every frame starts with a 4-bit header. That header takes one of two legal codes, so a random bit window rarely matches it. The aligner tests the header at one candidate boundary per frame. It moves that boundary by one bit for each miss, and declares lock once the header has matched for enough frames in a row. While locked, it tolerates short bursts of header errors. A longer burst drops lock and restarts the search.

The shift is split into two parts. A bit offset inside the input word drives a small barrel shifter. A one-word skip of the frame timer carries the offset past a word edge. As a result, the path from input word to output frame has the same register depth for every boundary position. An aligned frame always leaves the block one cycle after the word that holds its last bit. Downstream logic sees a frame strobe at the frame rate and a lock flag, and it can read the current slip position for monitoring.

Top module: `hdr_frame_aligner`

## Requirements
- R1: A frame is FRAME_W bits received most significant bit first. Bit IN_W-1 of `in_word` is the earliest bit of that word, so `frame_o[FRAME_W-1]` is the first bit of the frame on the line, and the header occupies `frame_o[FRAME_W-1:FRAME_W-4]`.
- R2: While locked, each frame appears on `frame_o` with `frame_vld_o` high in the cycle after the clock edge that captured the input word holding the frame's last bit. This latency is the same for every boundary offset.
- R3: Lock (`locked_o` high) is declared at the LOCK_FRAMES-th consecutive frame with a legal header at an unchanged offset. That frame is already output with `frame_vld_o`.
- R4: While searching, each frame with an illegal header advances `slip_o` by exactly one, wrapping from FRAME_W-1 to 0. Each step moves the assumed frame boundary one bit earlier in the stream, so a stream delayed by G bits relocks at a slip FRAME_W-G (mod FRAME_W) higher.
- R5: While locked, a run of fewer than UNLOCK_ERRS consecutive header errors keeps lock and leaves `slip_o` unchanged. The erroneous frames are still output.
- R6: The UNLOCK_ERRS-th consecutive header error drops `locked_o`, and that frame is not output. The search then restarts at the same offset with its good-frame count at zero.
- R7: `frame_vld_o` is high only while `locked_o` is high. While lock holds, strobes come exactly FRAME_W/IN_W cycles apart.
- R8: A synchronous active-high `rst` clears `locked_o`, `frame_vld_o`, `slip_o` and `frame_o` to zero.
- R9: Header codes 4'b0101 (data frame) and 4'b0110 (idle frame) are both legal. Every other 4-bit value is a header error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | IN_W | Received word, bit IN_W-1 earliest |
| frame_o | output | FRAME_W | Aligned frame, header in the top 4 bits |
| frame_vld_o | output | 1 | One-cycle strobe per aligned frame while locked |
| locked_o | output | 1 | Frame lock indication |
| slip_o | output | $clog2(FRAME_W) | Current boundary slip, 0 to FRAME_W-1 |

## Verification
The bench uses a 120-bit frame with 8-bit input words, so a frame lasts 15 cycles. It lowers the lock threshold to 8 frames and keeps the unlock threshold at 4. Under these values a full search, two error bursts, a relock in place and a second search after a 53-bit stream shift all fit in about six thousand cycles. The second search passes the slip wrap from 119 to 0. The start offset of 37 bits puts the frame end in the middle of a word, and the shift moves it to another in-word position. Checking every strobe against the word that carried the frame's last bit therefore covers the constant-latency claim at two different bit offsets.

// File: rtl/fa_pkg.sv
package fa_pkg;

    localparam int HDR_W = 4;
    localparam logic [HDR_W-1:0] HDR_DATA = 4'b0101;
    localparam logic [HDR_W-1:0] HDR_IDLE = 4'b0110;

    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_LOCKED = 1'b1
    } align_state_e;

    typedef struct packed {
        logic locked;       // registered lock state
        logic locked_next;  // lock state after the current edge
        logic wrap;         // bit offset wraps at this frame tick
    } align_ctl_t;

    function automatic logic hdr_is_legal(input logic [HDR_W-1:0] h);
        return (h == HDR_DATA) || (h == HDR_IDLE);
    endfunction

endpackage

// File: rtl/fa_word_buffer.sv
module fa_word_buffer #(
    parameter int IN_W  = 8,
    parameter int BUF_W = 127
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_word,
    output logic [BUF_W-1:0] buf_o
);
    logic [BUF_W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) buf_q <= '0;
        else     buf_q <= {buf_q[BUF_W-IN_W-1:0], in_word};
    end

    assign buf_o = buf_q;
endmodule

// File: rtl/fa_barrel.sv
module fa_barrel #(
    parameter int IN_W    = 8,
    parameter int FRAME_W = 120,
    parameter int BUF_W   = 127,
    parameter int OFF_W   = 3
) (
    input  logic [BUF_W-1:0]   buf_i,
    input  logic [OFF_W-1:0]   bit_off_i,
    output logic [FRAME_W-1:0] frame_o
);
    logic [FRAME_W-1:0] taps [IN_W];

    for (genvar k = 0; k < IN_W; k++) begin : g_tap
        assign taps[k] = buf_i[k +: FRAME_W];
    end

    assign frame_o = taps[bit_off_i];
endmodule

// File: rtl/fa_frame_timer.sv
module fa_frame_timer #(
    parameter int WPF = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic skip_i,
    output logic tick_o
);
    localparam int WC_W = (WPF > 1) ? $clog2(WPF) : 1;

    logic [WC_W-1:0] wcnt_q;

    assign tick_o = (wcnt_q == WC_W'(WPF - 1));

    always_ff @(posedge clk) begin
        if (rst)         wcnt_q <= '0;
        else if (tick_o) wcnt_q <= skip_i ? WC_W'(1) : '0;
        else             wcnt_q <= wcnt_q + WC_W'(1);
    end
endmodule

// File: rtl/fa_lock_fsm.sv
module fa_lock_fsm
    import fa_pkg::*;
#(
    parameter int FRAME_W     = 120,
    parameter int IN_W        = 8,
    parameter int LOCK_FRAMES = 32,
    parameter int UNLOCK_ERRS = 4,
    parameter int SLIP_W      = 7,
    parameter int OFF_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              hdr_ok_i,
    output align_ctl_t        ctl_o,
    output logic [SLIP_W-1:0] slip_o,
    output logic [OFF_W-1:0]  bit_off_o
);
    localparam int GOOD_W = $clog2(LOCK_FRAMES + 1);
    localparam int ERR_W  = $clog2(UNLOCK_ERRS + 1);

    align_state_e      st_q, st_d;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [ERR_W-1:0]  err_q, err_d;
    logic [SLIP_W-1:0] slip_q, slip_d;
    logic [OFF_W-1:0]  off_q, off_d;
    logic              wrap;

    always_comb begin
        st_d   = st_q;
        good_d = good_q;
        err_d  = err_q;
        slip_d = slip_q;
        off_d  = off_q;
        wrap   = 1'b0;
        if (tick_i) begin
            unique case (st_q)
                ST_SEARCH: begin
                    if (hdr_ok_i) begin
                        if (good_q == GOOD_W'(LOCK_FRAMES - 1)) begin
                            st_d   = ST_LOCKED;
                            good_d = '0;
                            err_d  = '0;
                        end else begin
                            good_d = good_q + GOOD_W'(1);
                        end
                    end else begin
                        good_d = '0;
                        slip_d = (slip_q == SLIP_W'(FRAME_W - 1)) ? '0 : slip_q + SLIP_W'(1);
                        if (off_q == OFF_W'(IN_W - 1)) begin
                            off_d = '0;
                            wrap  = 1'b1;
                        end else begin
                            off_d = off_q + OFF_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    if (hdr_ok_i) begin
                        err_d = '0;
                    end else if (err_q == ERR_W'(UNLOCK_ERRS - 1)) begin
                        st_d   = ST_SEARCH;
                        err_d  = '0;
                        good_d = '0;
                    end else begin
                        err_d = err_q + ERR_W'(1);
                    end
                end
                default: st_d = ST_SEARCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_SEARCH;
            good_q <= '0;
            err_q  <= '0;
            slip_q <= '0;
            off_q  <= '0;
        end else begin
            st_q   <= st_d;
            good_q <= good_d;
            err_q  <= err_d;
            slip_q <= slip_d;
            off_q  <= off_d;
        end
    end

    assign ctl_o.locked      = (st_q == ST_LOCKED);
    assign ctl_o.locked_next = (st_d == ST_LOCKED);
    assign ctl_o.wrap        = wrap;
    assign slip_o            = slip_q;
    assign bit_off_o         = off_q;
endmodule

// File: rtl/hdr_frame_aligner.sv
module hdr_frame_aligner
    import fa_pkg::*;
#(
    parameter int FRAME_W     = 120,
    parameter int IN_W        = 8,
    parameter int LOCK_FRAMES = 32,
    parameter int UNLOCK_ERRS = 4,
    localparam int SLIP_W     = $clog2(FRAME_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IN_W-1:0]    in_word,
    output logic [FRAME_W-1:0] frame_o,
    output logic               frame_vld_o,
    output logic               locked_o,
    output logic [SLIP_W-1:0]  slip_o
);
    localparam int WPF   = FRAME_W / IN_W;
    localparam int BUF_W = FRAME_W + IN_W - 1;
    localparam int OFF_W = (IN_W > 1) ? $clog2(IN_W) : 1;

    logic [BUF_W-1:0]   buf_w;
    logic [FRAME_W-1:0] cand;
    logic [OFF_W-1:0]   bit_off;
    logic               tick;
    logic               hdr_ok;
    align_ctl_t         ctl;
    logic [FRAME_W-1:0] frame_q;
    logic               vld_q;

    fa_word_buffer #(.IN_W(IN_W), .BUF_W(BUF_W)) u_buf (
        .clk(clk), .rst(rst), .in_word(in_word), .buf_o(buf_w)
    );

    fa_barrel #(.IN_W(IN_W), .FRAME_W(FRAME_W), .BUF_W(BUF_W), .OFF_W(OFF_W)) u_shift (
        .buf_i(buf_w), .bit_off_i(bit_off), .frame_o(cand)
    );

    fa_frame_timer #(.WPF(WPF)) u_timer (
        .clk(clk), .rst(rst), .skip_i(ctl.wrap), .tick_o(tick)
    );

    assign hdr_ok = hdr_is_legal(cand[FRAME_W-1 -: HDR_W]);

    fa_lock_fsm #(
        .FRAME_W(FRAME_W), .IN_W(IN_W), .LOCK_FRAMES(LOCK_FRAMES),
        .UNLOCK_ERRS(UNLOCK_ERRS), .SLIP_W(SLIP_W), .OFF_W(OFF_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick_i(tick), .hdr_ok_i(hdr_ok),
        .ctl_o(ctl), .slip_o(slip_o), .bit_off_o(bit_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= tick & ctl.locked_next;
            if (tick & ctl.locked_next) frame_q <= cand;
        end
    end

    assign frame_o     = frame_q;
    assign frame_vld_o = vld_q;
    assign locked_o    = ctl.locked;
endmodule

// File: rtl/fa_align_chk.sv
module fa_align_chk #(
    parameter int FRAME_W = 120,
    parameter int IN_W    = 8,
    localparam int SLIP_W = $clog2(FRAME_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_vld_o,
    input logic              locked_o,
    input logic [SLIP_W-1:0] slip_o
);
    localparam int WPF  = FRAME_W / IN_W;
    localparam int GAP_W = $clog2(WPF + 2) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (frame_vld_o)      gap_q <= GAP_W'(1);
            else if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
            if (frame_vld_o)      armed_q <= 1'b1;
            else if (!locked_o)   armed_q <= 1'b0;
        end
    end

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!locked_o && !frame_vld_o && slip_o == '0));

    // R7
    vld_needs_lock_chk: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> locked_o);

    // R7
    vld_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_vld_o && armed_q) |-> (gap_q == GAP_W'(WPF)));

    // R4
    slip_step_chk: assert property (@(posedge clk) disable iff (rst)
        (slip_o != $past(slip_o)) |->
            (slip_o == (($past(slip_o) == SLIP_W'(FRAME_W - 1)) ? '0 : $past(slip_o) + SLIP_W'(1))));

    // R5
    locked_slip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_o && $past(locked_o)) |-> $stable(slip_o));

    // R6
    unlock_no_slip_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_o) |-> $stable(slip_o));
endmodule

bind hdr_frame_aligner fa_align_chk #(.FRAME_W(FRAME_W), .IN_W(IN_W)) u_chk (
    .clk(clk), .rst(rst), .frame_vld_o(frame_vld_o),
    .locked_o(locked_o), .slip_o(slip_o)
);

// File: tb/sim_hdr_frame_aligner.sv
module sim_hdr_frame_aligner;
    localparam int FW  = 120;
    localparam int IW  = 8;
    localparam int LF  = 8;
    localparam int UE  = 4;
    localparam int WPF = FW / IW;
    localparam int SW  = $clog2(FW);
    localparam int P1  = 37;
    localparam int G   = 53;
    localparam int N1  = 200;
    localparam int NF  = 400;
    localparam int A   = 150;
    localparam int B   = 170;
    localparam int NB  = FW * NF + P1 + G;
    localparam int NW  = (NB + IW - 1) / IW;

    logic          clk = 1'b0;
    logic          rst;
    logic [IW-1:0] in_word;
    logic [FW-1:0] frame_o;
    logic          frame_vld_o;
    logic          locked_o;
    logic [SW-1:0] slip_o;

    always #4 clk = ~clk;

    hdr_frame_aligner #(.FRAME_W(FW), .IN_W(IW), .LOCK_FRAMES(LF), .UNLOCK_ERRS(UE)) u0 (
        .clk(clk), .rst(rst), .in_word(in_word), .frame_o(frame_o),
        .frame_vld_o(frame_vld_o), .locked_o(locked_o), .slip_o(slip_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic          sbit  [0:NB-1];
    logic [FW-1:0] fdata [0:NF-1];
    int            wmap  [0:NW-1];
    int            gstart_w;

    int prev_slip  = 0;
    int first_slip = -1;
    int last_vld_w = -1;
    int n_data = 0, n_idle = 0;
    bit was_locked = 0, trans = 0, trans_done = 0, seg2_dropped = 0, wrap_seen = 0, lock_cont = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit is_bad(input int j);
        return (j >= A && j < A + 3) || (j >= B && j < B + UE);
    endfunction

    function automatic logic [3:0] bad_hdr();
        logic [3:0] h;
        h = 4'($urandom);
        while (h == 4'b0101 || h == 4'b0110) h = 4'($urandom);
        return h;
    endfunction

    task automatic build_stream();
        int pos = 0;
        logic [127:0] pl;
        logic [3:0]   h;
        for (int i = 0; i < NW; i++) wmap[i] = 0;
        for (int i = 0; i < P1; i++) begin sbit[pos] = 1'($urandom); pos++; end
        for (int j = 0; j < NF; j++) begin
            if (j == N1) begin
                gstart_w = pos / IW;
                for (int i = 0; i < G; i++) begin sbit[pos] = 1'($urandom); pos++; end
            end
            pl = {$urandom, $urandom, $urandom, $urandom};
            if (is_bad(j))          h = bad_hdr();
            else if ($urandom & 1)  h = 4'b0101;
            else                    h = 4'b0110;
            fdata[j] = {h, pl[FW-5:0]};
            for (int i = 0; i < FW; i++) sbit[pos + i] = fdata[j][FW-1-i];
            wmap[(pos + FW - 1) / IW] = j + 1;
            pos += FW;
        end
    endtask

    task automatic drive_word(input int w);
        for (int b = 0; b < IW; b++)
            in_word[IW-1-b] = (w * IW + b < NB) ? sbit[w * IW + b] : 1'b0;
    endtask

    task automatic evaluate(input int w);
        int k = w - 2;
        int j = -1;
        if (k >= 0 && k < NW) j = wmap[k] - 1;

        if (int'(slip_o) != prev_slip) begin
            chk(int'(slip_o) == (prev_slip + 1) % FW, "R4 slip step", slip_o, (prev_slip + 1) % FW);
            if (prev_slip == FW - 1 && slip_o == 0) wrap_seen = 1;
            prev_slip = int'(slip_o);
        end

        if (!trans_done && k > gstart_w) begin trans = 1; trans_done = 1; end
        if (trans && !locked_o) begin trans = 0; seg2_dropped = 1; end

        if (locked_o && !was_locked && first_slip < 0) begin
            first_slip = int'(slip_o);
            chk(j >= 0 && j < A, "R3 first lock before error stage", j, A);
        end

        if (frame_vld_o) begin
            chk(locked_o, "R7 valid only while locked", locked_o, 1);
            if (!trans) begin
                if (j < 0) chk(0, "R2 valid with no frame ending in word", k, 0);
                else       chk(frame_o == fdata[j], "R1 R2 frame content and latency", frame_o, fdata[j]);
            end
            if (frame_o[FW-1 -: 4] == 4'b0101) n_data++;
            if (frame_o[FW-1 -: 4] == 4'b0110) n_idle++;
            if (lock_cont && last_vld_w >= 0)
                chk(w - last_vld_w == WPF, "R7 strobe spacing", w - last_vld_w, WPF);
            last_vld_w = w;
            lock_cont  = 1;
        end
        if (!locked_o) lock_cont = 0;

        if (j == A + 2)
            chk(locked_o && frame_vld_o && int'(slip_o) == first_slip, "R5 three errors keep lock",
                {locked_o, frame_vld_o, slip_o}, {2'b11, SW'(first_slip)});
        if (j == B + 2)
            chk(locked_o, "R5 lock held before fourth error", locked_o, 1);
        if (j == B + 3)
            chk(!locked_o && !frame_vld_o && int'(slip_o) == first_slip, "R6 fourth error drops lock",
                {locked_o, frame_vld_o, slip_o}, {2'b00, SW'(first_slip)});
        if (j == B + 3 + LF - 1)
            chk(!locked_o, "R3 no lock one frame early", locked_o, 0);
        if (j == B + 3 + LF)
            chk(locked_o && frame_vld_o && int'(slip_o) == first_slip, "R3 R6 relock in place",
                {locked_o, frame_vld_o, slip_o}, {2'b11, SW'(first_slip)});

        was_locked = locked_o;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        build_stream();
        rst = 1'b1;
        in_word = '0;
        repeat (3) @(negedge clk);
        chk(!locked_o && !frame_vld_o && slip_o == 0 && frame_o == 0, "R8 reset state",
            {locked_o, frame_vld_o, slip_o}, 0);
        rst = 1'b0;
        drive_word(0);
        for (int w = 1; w <= NW + 1; w++) begin
            @(negedge clk);
            evaluate(w);
            drive_word(w);
        end
        chk(locked_o, "R4 locked after shifted stream", locked_o, 1);
        chk(int'(slip_o) == (first_slip + FW - (G % FW)) % FW, "R4 relock slip after shift",
            slip_o, (first_slip + FW - (G % FW)) % FW);
        chk(wrap_seen, "R4 slip wrap 119 to 0", wrap_seen, 1);
        chk(seg2_dropped, "R6 stream shift drops lock", seg2_dropped, 1);
        chk(n_data > 0, "R9 data header accepted", n_data, 1);
        chk(n_idle > 0, "R9 idle header accepted", n_idle, 1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule